// File: doc/BRIEF.md
# Planar Graphics Write Datapath

This block forms the bytes that a CPU write places into four 8-bit display memory planes. From one CPU data byte, the four bytes held in the read latches and a small set of control settings, it produces one output byte per plane and a per-plane write enable. The memory, the read path and the CPU address mapping are kept outside. The block only decides what each plane receives and which planes take it.

The control settings are captured in registers when `cfg_load` is high at a clock edge. The data path itself is purely combinational, from `cpu_data`, `latch_bytes` and the stored settings to the outputs. There are four write modes:

- Mode 0 uses rotated CPU data, with a per-plane constant from set/reset.
- Mode 1 copies the latches.
- Mode 2 spreads one CPU bit across each plane.
- Mode 3 uses set/reset constants, with a mask taken from the rotated data.

In every mode except 1, a two-bit logic function combines the chosen source with the latch byte, and a bit mask picks latch or result bit by bit.

Top module: `planar_write_path`

## Requirements
- R1: After reset the stored settings are as follows. Write mode is 0, rotate count is 0, function is pass, set/reset and its enable are 0, and bit mask and map mask are all ones. So `plane_data` shows `cpu_data` on every plane and `plane_we` equals `cpu_wr` replicated.
- R2: Settings change only at a rising edge where `cfg_load` is 1. The outputs use the new settings from just after that edge. Setting inputs that change while `cfg_load` is 0 have no effect on the outputs.
- R3: The CPU byte is rotated right by `cfg_rot_count` (0 to 7) before any other operation. Result bit i is CPU bit (i+count) mod 8. A count of 0 leaves the data unrotated.
- R4: `cfg_func` combines the source byte with the plane's latch byte: 0 = source unchanged, 1 = AND, 2 = OR, 3 = XOR.
- R5: In write mode 0 (`cfg_write_mode`=0), plane n's source is the rotated CPU byte. The exception is when bit n of `cfg_sr_enable` is 1: the source is then bit n of `cfg_set_reset` copied into all 8 bits.
- R6: In write mode 1, plane n's output equals latch byte n exactly. Function, bit mask and rotation have no effect.
- R7: In write mode 2, plane n's source is unrotated CPU data bit n copied into all 8 bits.
- R8: In write mode 3, plane n's source is set/reset bit n copied into 8 bits, whatever `cfg_sr_enable` holds. The effective mask is the rotated CPU byte ANDed with `cfg_bit_mask`.
- R9: In modes 0, 2 and 3, an output bit whose effective mask bit is 0 equals the latch bit. An output bit whose mask bit is 1 equals the function result. The effective mask in modes 0 and 2 is `cfg_bit_mask`.
- R10: `plane_we` bit n equals `cpu_wr` AND bit n of the stored map mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the settings |
| cfg_load | input | 1 | Captures all setting inputs at the edge |
| cfg_set_reset | input | 4 | Per-plane constant bit |
| cfg_sr_enable | input | 4 | Per-plane constant enable for mode 0 |
| cfg_rot_count | input | 3 | Right-rotate count |
| cfg_func | input | 2 | Logic function code |
| cfg_write_mode | input | 2 | Write mode 0..3 |
| cfg_bit_mask | input | 8 | Bit mask |
| cfg_map_mask | input | 4 | Per-plane write gate |
| cpu_wr | input | 1 | CPU write in progress |
| cpu_data | input | 8 | CPU write byte |
| latch_bytes | input | 32 | Latch byte n at bits 8n+7:8n |
| plane_data | output | 32 | Plane byte n at bits 8n+7:8n |
| plane_we | output | 4 | Per-plane write enable |

## Verification
A corrupted stored setting shows on `plane_data` or `plane_we` as soon as data is presented. The outputs are combinational from the registers, so the fault is visible in the same cycle as the write that uses it, without waiting for a later pipeline stage. A wrong rotate index, swapped function code or inverted mask select shows as single wrong bits. For that reason, each mode is driven with asymmetric data and latch patterns, and every plane byte is compared against an independent model. A setting register that loads without `cfg_load` is caught by changing the setting inputs while no load is requested.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [1:0] {
        WM_DIRECT = 2'd0,
        WM_LATCH  = 2'd1,
        WM_SPREAD = 2'd2,
        WM_MASKED = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        LF_PASS = 2'd0,
        LF_AND  = 2'd1,
        LF_OR   = 2'd2,
        LF_XOR  = 2'd3
    } lfunc_e;

endpackage

// File: rtl/pw_ctrl_regs.sv
module pw_ctrl_regs #(
    parameter int NPLANE = 4,
    parameter int DW     = 8,
    localparam int CW    = $clog2(DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NPLANE-1:0] set_reset_i,
    input  logic [NPLANE-1:0] sr_enable_i,
    input  logic [CW-1:0]     rot_count_i,
    input  logic [1:0]        func_i,
    input  logic [1:0]        write_mode_i,
    input  logic [DW-1:0]     bit_mask_i,
    input  logic [NPLANE-1:0] map_mask_i,
    output logic [NPLANE-1:0] set_reset_o,
    output logic [NPLANE-1:0] sr_enable_o,
    output logic [CW-1:0]     rot_count_o,
    output pw_pkg::lfunc_e    func_o,
    output pw_pkg::wmode_e    write_mode_o,
    output logic [DW-1:0]     bit_mask_o,
    output logic [NPLANE-1:0] map_mask_o
);
    import pw_pkg::*;

    typedef struct packed {
        logic [NPLANE-1:0] sr;
        logic [NPLANE-1:0] sre;
        logic [CW-1:0]     rot;
        lfunc_e            func;
        wmode_e            mode;
        logic [DW-1:0]     bmask;
        logic [NPLANE-1:0] mmask;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (load) begin
            ctl_d.sr    = set_reset_i;
            ctl_d.sre   = sr_enable_i;
            ctl_d.rot   = rot_count_i;
            ctl_d.func  = lfunc_e'(func_i);
            ctl_d.mode  = wmode_e'(write_mode_i);
            ctl_d.bmask = bit_mask_i;
            ctl_d.mmask = map_mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.sr    <= '0;
            ctl_q.sre   <= '0;
            ctl_q.rot   <= '0;
            ctl_q.func  <= LF_PASS;
            ctl_q.mode  <= WM_DIRECT;
            ctl_q.bmask <= '1;
            ctl_q.mmask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign set_reset_o  = ctl_q.sr;
    assign sr_enable_o  = ctl_q.sre;
    assign rot_count_o  = ctl_q.rot;
    assign func_o       = ctl_q.func;
    assign write_mode_o = ctl_q.mode;
    assign bit_mask_o   = ctl_q.bmask;
    assign map_mask_o   = ctl_q.mmask;

    // R2
    settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ctl_q));

    // R2
    settings_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (map_mask_o == $past(map_mask_i)) && (bit_mask_o == $past(bit_mask_i)));

endmodule

// File: rtl/pw_rotate.sv
module pw_rotate #(
    parameter int DW  = 8,
    localparam int CW = $clog2(DW)
) (
    input  logic [DW-1:0] din,
    input  logic [CW-1:0] count,
    output logic [DW-1:0] dout
);
    always_comb begin
        for (int i = 0; i < DW; i++) begin
            dout[i] = din[(i + int'(count)) % DW];
        end
    end

    // R3
    rot_zero_chk: assert final ((count != '0) || (dout == din));
    // R3
    rot_ones_chk: assert final ($countones(dout) == $countones(din));

endmodule

// File: rtl/pw_plane_lane.sv
module pw_plane_lane #(
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  pw_pkg::wmode_e mode,
    input  pw_pkg::lfunc_e func,
    input  logic           sr_bit,
    input  logic           sre_bit,
    input  logic           cpu_bit,
    input  logic [DW-1:0]  rot_data,
    input  logic [DW-1:0]  bit_mask,
    input  logic [DW-1:0]  latch,
    output logic [DW-1:0]  dout
);
    import pw_pkg::*;

    logic [DW-1:0] src;
    logic [DW-1:0] alu;
    logic [DW-1:0] emask;

    // source selection per write mode
    always_comb begin
        unique case (mode)
            WM_DIRECT: src = sre_bit ? {DW{sr_bit}} : rot_data;
            WM_SPREAD: src = {DW{cpu_bit}};
            WM_MASKED: src = {DW{sr_bit}};
            default:   src = latch;
        endcase
    end

    // logic function against the latch
    always_comb begin
        unique case (func)
            LF_AND:  alu = src & latch;
            LF_OR:   alu = src | latch;
            LF_XOR:  alu = src ^ latch;
            default: alu = src;
        endcase
    end

    // effective mask
    always_comb begin
        unique case (mode)
            WM_MASKED: emask = rot_data & bit_mask;
            WM_LATCH:  emask = '0;
            default:   emask = bit_mask;
        endcase
    end

    assign dout = (alu & emask) | (latch & ~emask);

    // R9
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != WM_LATCH) |-> ((dout & ~bit_mask) == (latch & ~bit_mask)));

    // R8
    masked_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WM_MASKED) |-> ((dout & ~rot_data) == (latch & ~rot_data)));

    // R6
    latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WM_LATCH) |-> (dout == latch));

endmodule

// File: rtl/planar_write_path.sv
module planar_write_path #(
    parameter int NPLANE = 4,
    parameter int DW     = 8,
    localparam int CW    = $clog2(DW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load,
    input  logic [NPLANE-1:0]    cfg_set_reset,
    input  logic [NPLANE-1:0]    cfg_sr_enable,
    input  logic [CW-1:0]        cfg_rot_count,
    input  logic [1:0]           cfg_func,
    input  logic [1:0]           cfg_write_mode,
    input  logic [DW-1:0]        cfg_bit_mask,
    input  logic [NPLANE-1:0]    cfg_map_mask,
    input  logic                 cpu_wr,
    input  logic [DW-1:0]        cpu_data,
    input  logic [NPLANE*DW-1:0] latch_bytes,
    output logic [NPLANE*DW-1:0] plane_data,
    output logic [NPLANE-1:0]    plane_we
);
    import pw_pkg::*;

    logic [NPLANE-1:0] sr_q, sre_q, mmask_q;
    logic [CW-1:0]     rot_q;
    lfunc_e            func_q;
    wmode_e            mode_q;
    logic [DW-1:0]     bmask_q;
    logic [DW-1:0]     rot_data;

    pw_ctrl_regs #(.NPLANE(NPLANE), .DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (cfg_load),
        .set_reset_i (cfg_set_reset),
        .sr_enable_i (cfg_sr_enable),
        .rot_count_i (cfg_rot_count),
        .func_i      (cfg_func),
        .write_mode_i(cfg_write_mode),
        .bit_mask_i  (cfg_bit_mask),
        .map_mask_i  (cfg_map_mask),
        .set_reset_o (sr_q),
        .sr_enable_o (sre_q),
        .rot_count_o (rot_q),
        .func_o      (func_q),
        .write_mode_o(mode_q),
        .bit_mask_o  (bmask_q),
        .map_mask_o  (mmask_q)
    );

    pw_rotate #(.DW(DW)) u_rot (
        .din  (cpu_data),
        .count(rot_q),
        .dout (rot_data)
    );

    for (genvar n = 0; n < NPLANE; n++) begin : g_lane
        pw_plane_lane #(.DW(DW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (mode_q),
            .func    (func_q),
            .sr_bit  (sr_q[n]),
            .sre_bit (sre_q[n]),
            .cpu_bit (cpu_data[n % DW]),
            .rot_data(rot_data),
            .bit_mask(bmask_q),
            .latch   (latch_bytes[n*DW +: DW]),
            .dout    (plane_data[n*DW +: DW])
        );
    end

    assign plane_we = mmask_q & {NPLANE{cpu_wr}};

    // R10
    we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_we & ~mmask_q) == '0);

    // R10
    we_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |-> (plane_we == '0));

    // R6
    latch_mode_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == WM_LATCH) |-> (plane_data == latch_bytes));

endmodule

// File: tb/tb_planar_write_path.sv
module tb_planar_write_path;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [3:0]  cfg_set_reset = '0, cfg_sr_enable = '0, cfg_map_mask = '0;
    logic [2:0]  cfg_rot_count = '0;
    logic [1:0]  cfg_func = '0, cfg_write_mode = '0;
    logic [7:0]  cfg_bit_mask = '0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_data = '0;
    logic [31:0] latch_bytes = '0;
    logic [31:0] plane_data;
    logic [3:0]  plane_we;

    int n_run = 0, n_fail = 0;

    // model copies of the loaded settings
    logic [3:0] m_sr = 0, m_sre = 0, m_mm = 4'hF;
    logic [2:0] m_rot = 0;
    logic [1:0] m_fn = 0, m_md = 0;
    logic [7:0] m_bm = 8'hFF;

    always #4 clk = ~clk;

    planar_write_path dut (.*);

    function automatic logic [7:0] ror8(logic [7:0] d, logic [2:0] c);
        return (d >> c) | (d << (4'd8 - {1'b0, c}));
    endfunction

    function automatic logic [31:0] model(logic [7:0] cd, logic [31:0] lt);
        logic [31:0] r;
        logic [7:0] rd = ror8(cd, m_rot);
        for (int n = 0; n < 4; n++) begin
            logic [7:0] l = lt[n*8 +: 8];
            logic [7:0] s, a, m;
            case (m_md)
                2'd0: s = m_sre[n] ? {8{m_sr[n]}} : rd;
                2'd2: s = {8{cd[n]}};
                default: s = {8{m_sr[n]}};
            endcase
            case (m_fn)
                2'd1: a = s & l;
                2'd2: a = s | l;
                2'd3: a = s ^ l;
                default: a = s;
            endcase
            m = (m_md == 2'd3) ? (rd & m_bm) : m_bm;
            r[n*8 +: 8] = (m_md == 2'd1) ? l : ((a & m) | (l & ~m));
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_cfg(logic [1:0] md, logic [1:0] fn, logic [2:0] rot,
                            logic [3:0] sr, logic [3:0] sre, logic [7:0] bm, logic [3:0] mm);
        cfg_write_mode = md; cfg_func = fn; cfg_rot_count = rot;
        cfg_set_reset = sr; cfg_sr_enable = sre; cfg_bit_mask = bm; cfg_map_mask = mm;
        cfg_load = 1'b1;
        @(posedge clk); #1;
        cfg_load = 1'b0;
        m_md = md; m_fn = fn; m_rot = rot; m_sr = sr; m_sre = sre; m_bm = bm; m_mm = mm;
    endtask

    task automatic apply_check(string req, logic [7:0] cd, logic [31:0] lt);
        cpu_data = cd; latch_bytes = lt; cpu_wr = 1'b1;
        #1;
        check(req, plane_data, model(cd, lt));
        check(req, {28'd0, plane_we}, {28'd0, m_mm});
        cpu_wr = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        cpu_data = 8'hA5; latch_bytes = 32'h1234_5678; cpu_wr = 1'b1; #1;
        check("R1", plane_data, 32'hA5A5_A5A5);
        check("R1", {28'd0, plane_we}, 32'hF);
        cpu_wr = 1'b0; #1;
        check("R1", {28'd0, plane_we}, 32'h0);
    endtask

    task automatic t_rotate;
        for (int c = 0; c < 8; c++) begin
            load_cfg(2'd0, 2'd0, 3'(c), 4'h0, 4'h0, 8'hFF, 4'hF);
            apply_check("R3", 8'h01, 32'hFFFF_FFFF);
            check("R3", {24'd0, plane_data[7:0]}, {24'd0, 8'h01 << ((8 - c) % 8)});
        end
    endtask

    task automatic t_func;
        for (int f = 0; f < 4; f++) begin
            load_cfg(2'd0, 2'(f), 3'd3, 4'h0, 4'h0, 8'hFF, 4'hF);
            apply_check("R4", 8'hC6, 32'h0FF0_5A3C);
        end
    endtask

    task automatic t_mode0_sr;
        load_cfg(2'd0, 2'd0, 3'd1, 4'b0101, 4'b0011, 8'hFF, 4'hF);
        apply_check("R5", 8'h96, 32'h1122_3344);
        // plane0: enabled, sr=1 -> FF ; plane1: enabled sr=0 -> 00
        check("R5", {16'd0, plane_data[15:0]}, 32'h0000_00FF);
    endtask

    task automatic t_mode1;
        load_cfg(2'd1, 2'd3, 3'd5, 4'hF, 4'hF, 8'h0F, 4'hF);
        apply_check("R6", 8'hFF, 32'hDEAD_BEEF);
        check("R6", plane_data, 32'hDEAD_BEEF);
    endtask

    task automatic t_mode2;
        load_cfg(2'd2, 2'd0, 3'd2, 4'h0, 4'hF, 8'hFF, 4'hF);
        apply_check("R7", 8'b0000_1010, 32'h1234_5678);
        check("R7", plane_data, 32'hFF00_FF00);
        load_cfg(2'd2, 2'd2, 3'd0, 4'h0, 4'h0, 8'hF0, 4'hF);
        apply_check("R7", 8'b0000_0101, 32'h0102_0304);
    endtask

    task automatic t_mode3;
        load_cfg(2'd3, 2'd0, 3'd1, 4'b1010, 4'b0101, 8'hF3, 4'hF);
        apply_check("R8", 8'h5B, 32'h0000_0000);
        load_cfg(2'd3, 2'd3, 3'd4, 4'b0110, 4'hF, 8'hFF, 4'hF);
        apply_check("R8", 8'h3C, 32'hA5C3_0F69);
    endtask

    task automatic t_mask;
        load_cfg(2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'h00, 4'hF);
        apply_check("R9", 8'hFF, 32'h1357_9BDF);
        check("R9", plane_data, 32'h1357_9BDF);
        load_cfg(2'd0, 2'd1, 3'd0, 4'h0, 4'h0, 8'h5A, 4'hF);
        apply_check("R9", 8'h0F, 32'hFFFF_0000);
    endtask

    task automatic t_mapmask;
        load_cfg(2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 4'b1001);
        apply_check("R10", 8'h77, 32'h0);
        load_cfg(2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 4'b0110);
        apply_check("R10", 8'h77, 32'h0);
    endtask

    task automatic t_hold;
        load_cfg(2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 4'hF);
        cfg_write_mode = 2'd1; cfg_bit_mask = 8'h00; cfg_map_mask = 4'h0; cfg_rot_count = 3'd7;
        repeat (2) @(posedge clk);
        #1;
        apply_check("R2", 8'h3E, 32'h8421_8421);
        check("R2", plane_data, 32'h3E3E_3E3E);
    endtask

    initial begin
        #(8 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_rotate();
        t_func();
        t_mode0_sr();
        t_mode1();
        t_mode2();
        t_mode3();
        t_mask();
        t_mapmask();
        t_hold();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule